// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

A bank of four 32-bit periodic timers that share one register port. Each timer has a control field and a count register. A timer can run at its own count, or at its count multiplied by the count register of any timer in the bank, picked by a select field in its control word. This lets one timer act as a programmable prescaler for another. Timer 3 is meant to serve as the watchdog. Timers 0 to 2 are general purpose. Every timer drives its own single-cycle expiry pulse. What the pulses drive is left to logic outside the block.

Software sees counts in prescaled units, not raw clock ticks. A read of a running timer's count, or the disabling of a running timer, divides the remaining raw ticks by the timer's current scale. A shared sequential divider does this division, and the block reports busy while the divider works. The quotient goes back into the count register and, for a read, is also returned.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset, every control field and count register reads zero, no timer runs, no expiry pulse is driven, and busy and reg_rvalid are low.
- R2: Writing a control field whose enable bit (bit 0) goes from 0 to 1 starts the timer with period P = count × scale. The first expiry pulse comes P cycles after the write edge, and the timer then pulses every P cycles. Each pulse lasts one clock.
- R3: Control bit 1 enables prescaling, and control bits 3:2 pick the timer whose count register is the scale. With bit 1 clear, the scale is 1. Control fields are 4 bits wide and higher write bits are dropped.
- R4: If the period computed on enable is zero, the timer does not start and produces no pulses, while its enable bit still reads back as 1.
- R5: Clearing the enable bit of a running timer stops it at once. The remaining ticks divided by the pre-write scale are then stored in its count register.
- R6: A read of the count register of a running timer returns the remaining ticks divided by the scale, and that quotient is also written into the count register. reg_rvalid pulses in the cycle in which busy falls.
- R7: Writing the count register of an enabled timer restarts it with period new count × scale. The scale is taken from register contents before the write.
- R8: A read of a control field, or of the count register of a timer that is not running, returns the register value with reg_rvalid high in the cycle after the read.
- R9: Each division keeps busy high for 65 cycles after the accepted access. Reads and writes presented while busy is high are ignored and change no register or timer.
- R10: Timer 3, the watchdog, follows the same rules and drives expire[3].
- R11: A scale of zero at division time is treated as 1, so the quotient equals the remaining ticks truncated to 32 bits.
- R12: The register address uses bit 0 to pick the register (0 control, 1 count) and bits 2:1 to pick the timer. A write takes precedence over a read presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | {timer index, register select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid pulse |
| busy | output | 1 | Divider working; accesses are ignored |
| expire | output | 4 | One expiry pulse per timer |

## Verification
The assertions assume that reset is applied for at least one clock before any access. They also assume that an access ignored while busy is high is simply lost, and is not held for a retry. The bench issues one strobe per cycle and normally waits for busy to fall before the next access. It breaks this rule on purpose exactly once, to show that a write is ignored while busy is high. Prescale chains are built only from timers whose count registers are already set, so each expected period is a known product.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_PS_BIT = 1;
  localparam int CTRL_SEL_LSB = 2;
  localparam int DIV_EXTRA = 1;   // cycle spent handing the quotient back
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          stop,
  input  logic [TW-1:0] period_in,
  output logic          running,
  output logic [TW-1:0] remain,
  output logic          expire
);
  logic [TW-1:0] period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      remain   <= '0;
      period_q <= '0;
      expire   <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (stop) begin
        running <= 1'b0;
      end else if (load) begin
        running  <= (period_in != '0);
        remain   <= period_in;
        period_q <= period_in;
      end else if (running) begin
        if (remain == TW'(1)) begin
          expire <= 1'b1;
          remain <= period_q;
        end else begin
          remain <= remain - TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tmr_div.sv
module tmr_div #(
  parameter int NW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quo
);
  localparam int KW = $clog2(NW);

  logic [NW-1:0] q_q;
  logic [DW:0]   r_q;
  logic [DW-1:0] d_q;
  logic [KW-1:0] k_q;
  logic [DW:0]   shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {r_q[DW-1:0], q_q[NW-1]};
    ge      = shifted >= {1'b0, d_q};
    diff    = shifted - {1'b0, d_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q  <= '0;
      r_q  <= '0;
      d_q  <= '0;
      k_q  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        q_q  <= num;
        r_q  <= '0;
        d_q  <= (den == '0) ? DW'(1) : den;
        k_q  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        q_q <= {q_q[NW-2:0], ge};
        r_q <= ge ? diff : shifted;
        k_q <= k_q + KW'(1);
        if (k_q == KW'(NW - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q[DW-1:0];
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int NT = 4,
  parameter int DW = 32,
  localparam int AW = $clog2(NT) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic          busy,
  output logic [NT-1:0] expire
);
  import tmr_pkg::*;

  localparam int SW = $clog2(NT);
  localparam int CW = SW + 2;
  localparam int TW = 2 * DW;

  logic [CW-1:0] ctrl_q [NT];
  logic [DW-1:0] cnt_q  [NT];
  logic [DW-1:0] scale_cur [NT];
  logic [TW-1:0] ch_rem [NT];
  logic [NT-1:0] ch_run, ld, st;
  logic [TW-1:0] ld_per;

  logic [SW-1:0] acc_idx, pend_idx;
  logic          acc_cnt, wr_go, rd_go, old_en, pend_rd;
  logic [DW-1:0] wscale;
  logic          div_start, div_rd, div_busy, div_done;
  logic [TW-1:0] div_num;
  logic [DW-1:0] div_den, div_quo;

  assign busy    = div_busy | div_done;
  assign acc_idx = reg_addr[AW-1:1];
  assign acc_cnt = reg_addr[0];
  assign wr_go   = reg_wr && !busy;
  assign rd_go   = reg_rd && !busy && !reg_wr;
  assign old_en  = ctrl_q[acc_idx][CTRL_EN_BIT];
  assign wscale  = reg_wdata[CTRL_PS_BIT] ? cnt_q[reg_wdata[CW-1:CTRL_SEL_LSB]] : DW'(1);

  for (genvar g = 0; g < NT; g++) begin : g_scale
    assign scale_cur[g] = ctrl_q[g][CTRL_PS_BIT] ? cnt_q[ctrl_q[g][CW-1:CTRL_SEL_LSB]] : DW'(1);
  end

  always_comb begin
    ld = '0; st = '0; ld_per = '0;
    div_start = 1'b0; div_rd = 1'b0; div_num = '0; div_den = '0;
    if (wr_go && !acc_cnt) begin
      if (!old_en && reg_wdata[CTRL_EN_BIT]) begin
        ld[acc_idx] = 1'b1;
        ld_per = TW'(cnt_q[acc_idx]) * TW'(wscale);
      end else if (old_en && !reg_wdata[CTRL_EN_BIT]) begin
        st[acc_idx] = 1'b1;
        if (ch_run[acc_idx]) begin
          div_start = 1'b1;
          div_num   = ch_rem[acc_idx];
          div_den   = scale_cur[acc_idx];
        end
      end
    end else if (wr_go && acc_cnt && old_en) begin
      ld[acc_idx] = 1'b1;
      ld_per = TW'(reg_wdata) * TW'(scale_cur[acc_idx]);
    end else if (rd_go && acc_cnt && ch_run[acc_idx]) begin
      div_start = 1'b1;
      div_rd    = 1'b1;
      div_num   = ch_rem[acc_idx];
      div_den   = scale_cur[acc_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) begin
        ctrl_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      pend_idx   <= '0;
      pend_rd    <= 1'b0;
    end else begin
      reg_rvalid <= 1'b0;
      if (wr_go) begin
        if (acc_cnt) cnt_q[acc_idx]  <= reg_wdata;
        else         ctrl_q[acc_idx] <= reg_wdata[CW-1:0];
      end
      if (rd_go && !(acc_cnt && ch_run[acc_idx])) begin
        reg_rdata  <= acc_cnt ? cnt_q[acc_idx] : DW'(ctrl_q[acc_idx]);
        reg_rvalid <= 1'b1;
      end
      if (div_start) begin
        pend_idx <= acc_idx;
        pend_rd  <= div_rd;
      end
      if (div_done) begin
        cnt_q[pend_idx] <= div_quo;
        if (pend_rd) begin
          reg_rdata  <= div_quo;
          reg_rvalid <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_ch
    tmr_chan #(.TW(TW)) i_chan (
      .clk(clk), .rst(rst), .load(ld[g]), .stop(st[g]), .period_in(ld_per),
      .running(ch_run[g]), .remain(ch_rem[g]), .expire(expire[g])
    );
  end

  tmr_div #(.NW(TW), .DW(DW)) i_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NT = 4,
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          reg_rvalid,
  input logic          busy,
  input logic [NT-1:0] expire,
  input logic [NT-1:0] run,
  input logic [NT-1:0] ld,
  input logic [NT-1:0] st,
  input logic [TW-1:0] ld_per
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (expire == '0 && !reg_rvalid && !busy));

  assert_valid_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !(reg_rvalid && busy));

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && (reg_wr || reg_rd)) |-> (ld == '0 && st == '0));

  for (genvar g = 0; g < NT; g++) begin : g_a
    assert_expire_running_R2: assert property (@(posedge clk) disable iff (rst)
      expire[g] |-> $past(run[g]));

    assert_zero_no_start_R4: assert property (@(posedge clk) disable iff (rst)
      (ld[g] && !st[g] && ld_per == '0) |=> !run[g]);

    assert_stop_halts_R5: assert property (@(posedge clk) disable iff (rst)
      st[g] |=> (!run[g] && !expire[g]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NT(NT), .TW(TW)) i_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .busy(busy), .expire(expire), .run(ch_run), .ld(ld), .st(st), .ld_per(ld_per)
);

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  localparam int NT = 4;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int DIVLAT = 65;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic reg_rvalid, busy;
  logic [NT-1:0] expire;

  always #4 clk = ~clk;

  tmr_bank #(.NT(NT), .DW(DW)) i_tmr_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .busy(busy), .expire(expire)
  );

  int errors = 0, checks = 0;
  bit finished = 0, live = 0;
  string tag = "R1 reset";

  // behavioural reference state
  longint unsigned m_ctrl[NT], m_cnt[NT], m_rem[NT], m_per[NT];
  bit m_run[NT], m_exp[NT];
  int mbusy = 0;
  bit pend_rd = 0, m_rv = 0;
  longint unsigned pend_q = 0, m_rdv = 0;

  function automatic longint unsigned scale_of(longint unsigned c);
    return (c & 2) != 0 ? m_cnt[(c >> 2) & 3] : 1;
  endfunction

  function automatic longint unsigned divq(longint unsigned rem, longint unsigned s);
    return (rem / (s == 0 ? 1 : s)) & 64'hFFFF_FFFF;
  endfunction

  task automatic chk(bit ok, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    live = 1;
    if (rst) begin
      for (int i = 0; i < NT; i++) begin
        m_ctrl[i] = 0; m_cnt[i] = 0; m_rem[i] = 0; m_per[i] = 0;
        m_run[i] = 0; m_exp[i] = 0;
      end
      mbusy = 0; pend_rd = 0; m_rv = 0;
    end else begin
      int idx, ldi, sti;
      bit isc, ign, wr, rd;
      longint unsigned per, q;
      m_rv = 0;
      ign = mbusy > 0;
      if (ign) begin
        mbusy--;
        if (mbusy == 0 && pend_rd) begin m_rv = 1; m_rdv = pend_q; end
      end
      wr = reg_wr && !ign;
      rd = reg_rd && !ign && !reg_wr;
      idx = int'(reg_addr >> 1);
      isc = reg_addr[0];
      ldi = -1; sti = -1; per = 0;
      if (wr && !isc) begin
        if ((m_ctrl[idx] & 1) == 0 && reg_wdata[0]) begin
          ldi = idx; per = m_cnt[idx] * scale_of(reg_wdata & 15);
        end else if ((m_ctrl[idx] & 1) == 1 && !reg_wdata[0]) begin
          sti = idx;
          if (m_run[idx]) begin
            m_cnt[idx] = divq(m_rem[idx], scale_of(m_ctrl[idx]));
            pend_rd = 0; mbusy = DIVLAT;
          end
        end
        m_ctrl[idx] = reg_wdata & 15;
      end else if (wr && isc) begin
        if ((m_ctrl[idx] & 1) == 1) begin
          ldi = idx; per = longint'(reg_wdata) * scale_of(m_ctrl[idx]);
        end
        m_cnt[idx] = reg_wdata;
      end else if (rd) begin
        if (isc && m_run[idx]) begin
          q = divq(m_rem[idx], scale_of(m_ctrl[idx]));
          m_cnt[idx] = q; pend_q = q; pend_rd = 1; mbusy = DIVLAT;
        end else begin
          m_rv = 1; m_rdv = isc ? m_cnt[idx] : m_ctrl[idx];
        end
      end
      for (int i = 0; i < NT; i++) begin
        m_exp[i] = 0;
        if (i == sti) m_run[i] = 0;
        else if (i == ldi) begin
          m_run[i] = per != 0; m_rem[i] = per; m_per[i] = per;
        end else if (m_run[i]) begin
          if (m_rem[i] == 1) begin m_exp[i] = 1; m_rem[i] = m_per[i]; end
          else m_rem[i]--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (live && !finished) begin
      for (int i = 0; i < NT; i++)
        chk(expire[i] == m_exp[i], $sformatf("expire[%0d] (R2/R10)", i), expire[i], m_exp[i]);
      chk(busy == (mbusy > 0), "busy window R9", busy, mbusy > 0);
      chk(reg_rvalid == m_rv, "rvalid R8", reg_rvalid, m_rv);
      if (reg_rvalid && m_rv)
        chk(reg_rdata == m_rdv[DW-1:0], "read data R6/R8", reg_rdata, m_rdv);
    end
  end

  task automatic wr(input int a, input longint unsigned d);
    @(negedge clk);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_wr = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    reg_rd = 1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
    end
  end

  initial begin
    idle(4);
    rst = 0;
    // R1: reset contents
    tag = "R1 reset";
    chk(expire == '0, "expire after reset R1", expire, 0);
    rd(0); rd(1); rd(7);
    // R2: plain period of 5 on timer 0
    tag = "R2 plain";
    wr(1, 5); wr(0, 1); idle(20);
    // R10: watchdog timer 3, period 7
    tag = "R10 watchdog";
    wr(7, 7); wr(6, 1); idle(16);
    // R3: timer 2 prescaled by timer 1 (count 3): period 4*3
    tag = "R3 prescale";
    wr(3, 3); wr(5, 4); wr(4, 32'hF0 | 7); rd(4); idle(30);
    // R6: read running counts
    tag = "R6 read running";
    rd(5); rd(1); idle(5);
    // R7: rewrite count while enabled
    tag = "R7 restart";
    wr(1, 3); idle(10);
    // R5: disable timer 2, count written back
    tag = "R5 disable";
    idle(2); wr(4, 0); rd(5); idle(15);
    // R4: zero product does not start
    tag = "R4 zero";
    wr(3, 0); wr(2, 1); rd(2); rd(3); idle(10);
    // R9: write while busy is ignored
    tag = "R9 busy";
    @(negedge clk); reg_rd = 1; reg_addr = 3'd1;
    @(negedge clk); reg_rd = 0; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 0;
    @(negedge clk); reg_wr = 0;
    while (busy) @(negedge clk);
    idle(1); rd(0); idle(6);
    // R11: zero scale at division time
    tag = "R11 zero scale";
    wr(0, 0); wr(3, 2); wr(1, 4); wr(0, 7); idle(3); wr(3, 0); rd(1); idle(10);
    // R12: write wins over read in the same cycle
    tag = "R12 address";
    @(negedge clk); reg_wr = 1; reg_rd = 1; reg_addr = 3'd5; reg_wdata = 9;
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    idle(3); rd(5); idle(4);
    summary();
  end
endmodule